// File: doc/BRIEF.md
# Flash Lock-Bit Command Controller

This block is the command front end and the internal sequencer that look after the per-block lock bits of a flash-style memory model. The bus issues byte writes with an address. The block reads them as two-write command sequences. A setup write followed by one confirm code locks the block that the confirm address falls in. The same setup followed by another confirm code unlocks every block at once. Before it starts a change, the block checks a write-protect input and a programming-voltage-valid flag. While the change runs, the block holds a busy pin low for a fixed, parameterised number of clock cycles.

An 8-bit status word reports progress and failures. Bit 7 is ready. Bit 5 flags an unlock failure and bit 4 flags a lock failure. Bit 3 flags a missing programming voltage and bit 1 flags active write protection. Error bits are sticky until a clear-status command. Once a lock sequence starts, bus reads return the status word until a read-array command. A supply loss or an abort can interrupt an unlock that is running. The lock bits are then reported as not trustworthy until a later unlock completes.

Command codes: 0x60 lock setup, 0x01 lock-one confirm, 0xD0 unlock-all confirm, 0x50 clear status, 0xFF read array. The block index is `addr[BLK_LSB +: log2(NUM_BLK)]`, and NUM_BLK must be a power of two of at least 2. Array data is not modelled: in array mode, reads return 0x00.

Top module: `lockbit_ctrl`

## Requirements
- R1: After reset, rd_data is 0x00 (array mode), busy_n is 1, lock_bits is all zero and lock_known is 1.
- R2: Writing 0x60 and then 0x01 with write protect off (wp_n=1) and vpp_ok=1 sets lock bit `addr[BLK_LSB +: log2(NUM_BLK)]` of the confirm write when the operation ends. Other lock bits do not change.
- R3: Writing 0x60 and then 0xD0 with wp_n=1 and vpp_ok=1 clears all lock bits when the operation ends, and sets lock_known to 1.
- R4: After an accepted confirm, busy_n is 0 and status bit 7 is 0 for exactly SET_CYC cycles (lock) or CLR_CYC cycles (unlock), starting in the cycle after the confirm write. Both then return to 1.
- R5: After a setup write, reads return the status word {bit7 ready, bit5 unlock error, bit4 lock error, bit3 voltage error, bit1 protect error, other bits 0}. This continues until a 0xFF write in the idle state. A 0x50 write keeps the read mode and clears bits 5, 4, 3 and 1.
- R6: After a setup write, any confirm data other than 0x01 or 0xD0 sets status bits 4 and 5, starts no busy period and changes no lock bit.
- R7: A confirm with wp_n=0 starts no busy period and changes no lock bit. It sets status bits 1 and 4 for a lock, or bits 1 and 5 for an unlock.
- R8: A confirm with vpp_ok=0 starts no busy period and changes no lock bit. It sets status bits 3 and 4 for a lock, or bits 3 and 5 for an unlock. This is in addition to R7 bits when both causes are present.
- R9: Error status bits stay set through later successful operations until a 0x50 write.
- R10: Bus writes made while busy_n is 0 have no effect on the command state, the read mode or the status word.
- R11: If supply_ok is 0 at a clock edge while busy, the operation ends. For an unlock, status bit 5 is set and lock_known drops to 0. For a lock, status bit 4 is set and the lock bits are unchanged. A later completed unlock sets lock_known back to 1.
- R12: A cycle with abort=1 returns the block to idle array mode and resets the status word to 0x80, with no busy. If an unlock was running, lock_known drops to 0 and the lock bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| addr | input | ADDR_W | Bus write address |
| wdata | input | 8 | Bus write data (command code) |
| rd_data | output | 8 | Read data: status word in status mode, else 0x00 |
| wp_n | input | 1 | Write protect, active low |
| vpp_ok | input | 1 | Programming voltage valid |
| supply_ok | input | 1 | Core supply valid |
| abort | input | 1 | Abort / reset-pin event |
| busy_n | output | 1 | Ready/busy pin, low while an operation runs |
| lock_bits | output | NUM_BLK | Current lock bit per block |
| lock_known | output | 1 | Lock bits are trustworthy |

## Verification
The hardest states to reach from the ports are interruptions in the middle of an operation. These are a supply drop or an abort inside the busy window, and bus writes landing there. The random stimulus almost never produces them in a way that can be checked, because it waits for each operation to end. Directed sequences therefore start an unlock or a lock and count cycles on busy_n. They drop supply_ok or raise abort a fixed number of cycles in. Then they check lock_known, the lock bits and the status word, and confirm that a later unlock recovers the trust flag. The random part mixes lock and unlock sequences with random protect and voltage inputs, random bad confirm codes, clear-status and read-array commands, and stray codes. A bench model predicts the status word and the lock vector after every step.

// File: rtl/lkc_pkg.sv
package lkc_pkg;

    localparam logic [7:0] CMD_LOCK_SETUP = 8'h60;
    localparam logic [7:0] CMD_LOCK_ONE   = 8'h01;
    localparam logic [7:0] CMD_UNLOCK_ALL = 8'hD0;
    localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

    localparam int SR_READY  = 7;
    localparam int SR_CLRERR = 5;
    localparam int SR_SETERR = 4;
    localparam int SR_VPPERR = 3;
    localparam int SR_WPERR  = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_BUSY  = 2'd2
    } lkc_state_e;

    typedef enum logic {
        OP_LOCK   = 1'b0,
        OP_UNLOCK = 1'b1
    } lkc_op_e;

    // decoded write, already qualified by the current state
    typedef struct packed {
        logic setup;
        logic to_array;
        logic cf_lock;
        logic cf_unlock;
        logic bad;
    } lkc_cmd_t;

    // single-cycle outcome events from the sequencer
    typedef struct packed {
        logic lock_done;
        logic unlock_done;
        logic lock_fail;
        logic unlock_fail;
        logic wp_fail;
        logic vpp_fail;
        logic seq_bad;
        logic trust_lost;
    } lkc_evt_t;

    typedef struct packed {
        logic clr;
        logic set;
        logic vpp;
        logic wp;
    } lkc_err_t;

    function automatic logic [7:0] sr_pack(input logic ready, input lkc_err_t e);
        logic [7:0] w;
        w = 8'h00;
        w[SR_READY]  = ready;
        w[SR_CLRERR] = e.clr;
        w[SR_SETERR] = e.set;
        w[SR_VPPERR] = e.vpp;
        w[SR_WPERR]  = e.wp;
        return w;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lkc_cmd_dec.sv
module lkc_cmd_dec
    import lkc_pkg::*;
(
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  lkc_state_e st,
    output lkc_cmd_t   cmd,
    output logic       clr_sr
);
    always_comb begin
        cmd    = '0;
        clr_sr = 1'b0;
        if (wr_en) begin
            unique case (st)
                ST_IDLE: begin
                    cmd.setup    = (wdata == CMD_LOCK_SETUP);
                    cmd.to_array = (wdata == CMD_READ_ARRAY);
                    clr_sr       = (wdata == CMD_CLR_STATUS);
                end
                ST_SETUP: begin
                    cmd.cf_lock   = (wdata == CMD_LOCK_ONE);
                    cmd.cf_unlock = (wdata == CMD_UNLOCK_ALL);
                    cmd.bad       = (wdata != CMD_LOCK_ONE) && (wdata != CMD_UNLOCK_ALL);
                end
                default: ;  // busy: writes are dropped
            endcase
        end
    end
endmodule

// File: rtl/lkc_seq.sv
module lkc_seq
    import lkc_pkg::*;
#(
    parameter int BLK_W   = 3,
    parameter int SET_CYC = 5,
    parameter int CLR_CYC = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             supply_ok,
    input  logic             wp_n,
    input  logic             vpp_ok,
    input  lkc_cmd_t         cmd,
    input  logic [BLK_W-1:0] blk_in,
    output lkc_state_e       st,
    output logic             busy,
    output logic             stat_mode,
    output logic [BLK_W-1:0] blk_tgt,
    output lkc_evt_t         evt
);
    localparam int MAXC  = max_int(SET_CYC, CLR_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    lkc_state_e       st_q, st_d;
    lkc_op_e          op_q, op_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [BLK_W-1:0] blk_q, blk_d;
    logic             mode_q, mode_d;
    logic             rej_wp, rej_vpp;

    assign rej_wp  = !wp_n;
    assign rej_vpp = !vpp_ok;

    always_comb begin
        st_d   = st_q;
        op_d   = op_q;
        cnt_d  = cnt_q;
        blk_d  = blk_q;
        mode_d = mode_q;
        evt    = '0;
        if (abort) begin
            st_d   = ST_IDLE;
            mode_d = 1'b0;
            evt.trust_lost = (st_q == ST_BUSY) && (op_q == OP_UNLOCK);
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (cmd.setup) begin
                        st_d   = ST_SETUP;
                        mode_d = 1'b1;
                    end else if (cmd.to_array) begin
                        mode_d = 1'b0;
                    end
                end
                ST_SETUP: begin
                    if (cmd.bad) begin
                        st_d        = ST_IDLE;
                        evt.seq_bad = 1'b1;
                    end else if (cmd.cf_lock || cmd.cf_unlock) begin
                        if (rej_wp || rej_vpp) begin
                            st_d            = ST_IDLE;
                            evt.wp_fail     = rej_wp;
                            evt.vpp_fail    = rej_vpp;
                            evt.lock_fail   = cmd.cf_lock;
                            evt.unlock_fail = cmd.cf_unlock;
                        end else begin
                            st_d  = ST_BUSY;
                            op_d  = cmd.cf_lock ? OP_LOCK : OP_UNLOCK;
                            blk_d = blk_in;
                            cnt_d = cmd.cf_lock ? CNT_W'(SET_CYC - 1) : CNT_W'(CLR_CYC - 1);
                        end
                    end
                end
                ST_BUSY: begin
                    if (!supply_ok) begin
                        st_d            = ST_IDLE;
                        evt.lock_fail   = (op_q == OP_LOCK);
                        evt.unlock_fail = (op_q == OP_UNLOCK);
                        evt.trust_lost  = (op_q == OP_UNLOCK);
                    end else if (cnt_q == '0) begin
                        st_d            = ST_IDLE;
                        evt.lock_done   = (op_q == OP_LOCK);
                        evt.unlock_done = (op_q == OP_UNLOCK);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_LOCK;
            cnt_q  <= '0;
            blk_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            op_q   <= op_d;
            cnt_q  <= cnt_d;
            blk_q  <= blk_d;
            mode_q <= mode_d;
        end
    end

    assign st        = st_q;
    assign busy      = (st_q == ST_BUSY);
    assign stat_mode = mode_q;
    assign blk_tgt   = blk_q;
endmodule

// File: rtl/lkc_lockreg.sv
module lkc_lockreg #(
    parameter int NUM_BLK = 8,
    parameter int BLK_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lock_done,
    input  logic               unlock_done,
    input  logic               trust_lost,
    input  logic [BLK_W-1:0]   blk,
    output logic [NUM_BLK-1:0] lock_bits,
    output logic               lock_known
);
    for (genvar i = 0; i < NUM_BLK; i++) begin : g_bit
        logic hit;
        assign hit = lock_done && (blk == BLK_W'(i));
        always_ff @(posedge clk) begin
            if (rst || unlock_done)
                lock_bits[i] <= 1'b0;
            else if (hit)
                lock_bits[i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || unlock_done)
            lock_known <= 1'b1;
        else if (trust_lost)
            lock_known <= 1'b0;
    end
endmodule

// File: rtl/lkc_status.sv
module lkc_status
    import lkc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       abort,
    input  logic       clr_sr,
    input  logic       ready,
    input  logic       seq_bad,
    input  logic       lock_fail,
    input  logic       unlock_fail,
    input  logic       wp_fail,
    input  logic       vpp_fail,
    output logic [7:0] status
);
    lkc_err_t err_q;

    always_ff @(posedge clk) begin
        if (rst || abort || clr_sr) begin
            err_q <= '0;
        end else begin
            err_q.clr <= err_q.clr | seq_bad | unlock_fail;
            err_q.set <= err_q.set | seq_bad | lock_fail;
            err_q.vpp <= err_q.vpp | vpp_fail;
            err_q.wp  <= err_q.wp  | wp_fail;
        end
    end

    assign status = sr_pack(ready, err_q);
endmodule

// File: rtl/lockbit_ctrl.sv
module lockbit_ctrl
    import lkc_pkg::*;
#(
    parameter int NUM_BLK = 8,
    parameter int ADDR_W  = 16,
    parameter int BLK_LSB = 12,
    parameter int SET_CYC = 5,
    parameter int CLR_CYC = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rd_data,
    input  logic               wp_n,
    input  logic               vpp_ok,
    input  logic               supply_ok,
    input  logic               abort,
    output logic               busy_n,
    output logic [NUM_BLK-1:0] lock_bits,
    output logic               lock_known
);
    localparam int BLK_W = $clog2(NUM_BLK);
    localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'((NUM_BLK - 1) << BLK_LSB);

    lkc_state_e       st;
    lkc_cmd_t         cmd;
    lkc_evt_t         evt;
    logic             clr_sr;
    logic             busy;
    logic             stat_mode;
    logic [BLK_W-1:0] blk_in;
    logic [BLK_W-1:0] blk_tgt;
    logic [7:0]       status_w;
    logic             addr_unused;

    assign blk_in      = addr[BLK_LSB +: BLK_W];
    assign addr_unused = ^(addr & ~BLK_MASK);

    lkc_cmd_dec u_dec (
        .wr_en  (wr_en),
        .wdata  (wdata),
        .st     (st),
        .cmd    (cmd),
        .clr_sr (clr_sr)
    );

    lkc_seq #(
        .BLK_W   (BLK_W),
        .SET_CYC (SET_CYC),
        .CLR_CYC (CLR_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .abort     (abort),
        .supply_ok (supply_ok),
        .wp_n      (wp_n),
        .vpp_ok    (vpp_ok),
        .cmd       (cmd),
        .blk_in    (blk_in),
        .st        (st),
        .busy      (busy),
        .stat_mode (stat_mode),
        .blk_tgt   (blk_tgt),
        .evt       (evt)
    );

    lkc_lockreg #(
        .NUM_BLK (NUM_BLK),
        .BLK_W   (BLK_W)
    ) u_lock (
        .clk         (clk),
        .rst         (rst),
        .lock_done   (evt.lock_done),
        .unlock_done (evt.unlock_done),
        .trust_lost  (evt.trust_lost),
        .blk         (blk_tgt),
        .lock_bits   (lock_bits),
        .lock_known  (lock_known)
    );

    lkc_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .abort       (abort),
        .clr_sr      (clr_sr),
        .ready       (!busy),
        .seq_bad     (evt.seq_bad),
        .lock_fail   (evt.lock_fail),
        .unlock_fail (evt.unlock_fail),
        .wp_fail     (evt.wp_fail),
        .vpp_fail    (evt.vpp_fail),
        .status      (status_w)
    );

    assign rd_data = stat_mode ? status_w : 8'h00;
    assign busy_n  = !busy;
endmodule

// File: rtl/lkc_checker.sv
module lkc_checker #(
    parameter int NUM_BLK = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               abort,
    input logic               busy_n,
    input logic [7:0]         rd_data,
    input logic [NUM_BLK-1:0] lock_bits,
    input logic               lock_known,
    input logic               ev_lock_done,
    input logic               ev_unlock_done,
    input logic               ev_seq_bad,
    input logic               ev_wp_fail,
    input logic               stat_mode
);
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ev_lock_done && !ev_unlock_done) |=> $stable(lock_bits)); // R2

    AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ev_unlock_done |=> (lock_bits == '0) && lock_known); // R3

    AST_BAD_SEQ_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (ev_seq_bad && !abort) |=> (rd_data[5:4] == 2'b11) && busy_n); // R6

    AST_WP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ev_wp_fail && !abort) |=> rd_data[1]); // R7

    AST_BUSY_MODE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!busy_n && !abort) |=> stat_mode); // R10

    AST_ABORT_ARRAY: assert property (@(posedge clk) disable iff (rst)
        abort |=> (rd_data == 8'h00) && busy_n); // R12
endmodule

bind lockbit_ctrl lkc_checker #(.NUM_BLK(NUM_BLK)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .abort          (abort),
    .busy_n         (busy_n),
    .rd_data        (rd_data),
    .lock_bits      (lock_bits),
    .lock_known     (lock_known),
    .ev_lock_done   (evt.lock_done),
    .ev_unlock_done (evt.unlock_done),
    .ev_seq_bad     (evt.seq_bad),
    .ev_wp_fail     (evt.wp_fail),
    .stat_mode      (stat_mode)
);

// File: tb/lockbit_ctrl_tb.sv
module lockbit_ctrl_tb;
    localparam int NB   = 8;
    localparam int AW   = 16;
    localparam int LSB  = 12;
    localparam int SETC = 5;
    localparam int CLRC = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rd_data;
    logic          wp_n = 1'b1;
    logic          vpp_ok = 1'b1;
    logic          supply_ok = 1'b1;
    logic          abort = 1'b0;
    logic          busy_n;
    logic [NB-1:0] lock_bits;
    logic          lock_known;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // bench model
    logic [NB-1:0] m_lock = '0;
    logic          m_known = 1'b1;
    logic [7:0]    m_err = 8'h00;   // error bits only
    logic          m_smode = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    lockbit_ctrl #(.NUM_BLK(NB), .ADDR_W(AW), .BLK_LSB(LSB),
                   .SET_CYC(SETC), .CLR_CYC(CLRC)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .wp_n(wp_n), .vpp_ok(vpp_ok), .supply_ok(supply_ok),
        .abort(abort), .busy_n(busy_n), .lock_bits(lock_bits), .lock_known(lock_known));

    function automatic logic [7:0] exp_rd();
        return m_smode ? (8'h80 | m_err) : 8'h00;
    endfunction

    function automatic logic [AW-1:0] addr_of(input int blk);
        logic [AW-1:0] a;
        a = AW'($urandom);
        a[LSB +: 3] = 3'(blk);
        return a;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " rd_data"}, 32'(rd_data), 32'(exp_rd()));
        chk({tag, " lock_bits"}, 32'(lock_bits), 32'(m_lock));
        chk({tag, " lock_known"}, 32'(lock_known), 32'(m_known));
        chk({tag, " busy_n"}, 32'(busy_n), 32'd1);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!busy_n && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // full lock or unlock sequence with model update; R2 R3 R4 R7 R8
    task automatic lock_op(input bit is_lock, input int blk, input bit w, input bit v);
        int n;
        wp_n = w; vpp_ok = v;
        wr(AW'($urandom), 8'h60);
        m_smode = 1'b1;
        chk("R5 status after setup", 32'(rd_data), 32'(exp_rd()));
        wr(addr_of(blk), is_lock ? 8'h01 : 8'hD0);
        if (w && v) begin
            chk("R4 busy starts", 32'(busy_n), 32'd0);
            busy_len(n);
            chk(is_lock ? "R4 lock busy length" : "R4 unlock busy length", 32'(n),
                32'(is_lock ? SETC : CLRC));
            if (is_lock) m_lock[blk] = 1'b1;
            else begin m_lock = '0; m_known = 1'b1; end
        end else begin
            if (!w) m_err[1] = 1'b1;
            if (!v) m_err[3] = 1'b1;
            if (is_lock) m_err[4] = 1'b1; else m_err[5] = 1'b1;
        end
        chk_all(is_lock ? "R2 R7 R8 lock" : "R3 R7 R8 unlock");
        wp_n = 1'b1; vpp_ok = 1'b1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog act=%0d exp=done", cyc);
                $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int n;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_all("R1 reset");

        // R2 lock two blocks, R4 lengths
        lock_op(1, 3, 1, 1);
        lock_op(1, 6, 1, 1);
        // R5 read array returns to 0x00
        wr('0, 8'hFF); m_smode = 1'b0;
        chk_all("R5 read array");
        // R6 bad confirm
        wr('0, 8'h60); wr(addr_of(1), 8'h20);
        m_smode = 1'b1; m_err[5:4] = 2'b11;
        chk_all("R6 bad confirm");
        // R5 clear status keeps status mode
        wr('0, 8'h50); m_err = 8'h00;
        chk_all("R5 clear status");
        // R7 protect on lock, R9 sticky through good op
        lock_op(1, 0, 0, 1);
        chk("R7 lock wp status", 32'(rd_data), 32'h92);
        lock_op(1, 1, 1, 1);
        chk("R9 sticky", 32'(rd_data), 32'h92);
        wr('0, 8'h50); m_err = 8'h00;
        // R8 both causes on unlock
        lock_op(0, 0, 0, 0);
        chk("R8 unlock wp+vpp status", 32'(rd_data), 32'hAA);
        wr('0, 8'h50); m_err = 8'h00;
        lock_op(0, 0, 1, 0);
        chk("R8 unlock vpp status", 32'(rd_data), 32'hA8);
        wr('0, 8'h50); m_err = 8'h00;

        // R10 writes during busy ignored
        wr('0, 8'h60); wr(addr_of(2), 8'h01);
        wr('0, 8'h60); wr('0, 8'hFF); wr('0, 8'h50);
        busy_len(n);
        m_lock[2] = 1'b1;
        chk_all("R10 after busy writes");
        wr('0, 8'hD0);  // idle: must not start an unlock
        chk_all("R10 no pending setup");

        // R11 supply loss during unlock
        wr('0, 8'h60); wr('0, 8'hD0);
        @(negedge clk); @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        m_known = 1'b0; m_err[5] = 1'b1;
        chk_all("R11 unlock lost");
        wr('0, 8'h50); m_err = 8'h00;
        // R11 supply loss during lock keeps bits
        wr('0, 8'h60); wr(addr_of(5), 8'h01);
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        m_err[4] = 1'b1;
        chk_all("R11 lock lost");
        wr('0, 8'h50); m_err = 8'h00;
        lock_op(0, 0, 1, 1);
        chk("R11 trust restored", 32'(lock_known), 32'd1);

        // R12 abort during unlock
        lock_op(1, 7, 1, 1);
        wr('0, 8'h60); wr('0, 8'hD0);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        m_known = 1'b0; m_smode = 1'b0; m_err = 8'h00;
        chk_all("R12 abort unlock");
        // R12 abort in status mode with errors
        wr('0, 8'h60); wr('0, 8'h33);
        @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
        chk_all("R12 abort idle");
        wr('0, 8'h60); m_smode = 1'b1;
        chk("R12 status reset", 32'(rd_data), 32'h80);
        wr('0, 8'h22);
        m_err[5:4] = 2'b11;
        lock_op(0, 0, 1, 1);

        // random phase
        for (int k = 0; k < 300; k++) begin
            int sel;
            logic [7:0] d;
            sel = int'($urandom_range(0, 5));
            case (sel)
                0: lock_op(1, int'($urandom_range(0, NB - 1)),
                           ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0));
                1: lock_op(0, 0, ($urandom_range(0, 4) != 0), ($urandom_range(0, 4) != 0));
                2: begin
                    d = 8'($urandom);
                    if (d == 8'h01 || d == 8'hD0) d = 8'h20;
                    wr('0, 8'h60); wr(AW'($urandom), d);
                    m_smode = 1'b1; m_err[5:4] = 2'b11;
                    chk_all("R6 random bad confirm");
                end
                3: begin
                    wr('0, 8'h50); m_err = 8'h00;
                    chk_all("R5 R9 random clear status");
                end
                4: begin
                    wr('0, 8'hFF); m_smode = 1'b0;
                    chk_all("R5 random read array");
                end
                default: begin
                    d = 8'($urandom);
                    if (d == 8'h60 || d == 8'h50 || d == 8'hFF) d = 8'h01;
                    wr(AW'($urandom), d);
                    chk_all("R10 R5 stray idle code");
                end
            endcase
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule